// File: doc/BRIEF.md
# Frame Buffer Burst Writer

This block sits between a camera capture front end and a memory. The capture side offers one group of eight 32-bit words (32 bytes) at a time through a request/acknowledge handshake. The writer accepts each group and writes it out as a burst of eight single-word beats on a simple memory write port. A write address and a count of the bursts still owed in the current frame are kept inside the block. The default frame length is 4800 bursts, which holds one 320x240 image at two bytes per pixel.

The frame-sync input re-aligns the writer. On each rising edge it samples the base address input and sets the write address back to that base. It also reloads the burst count, whether or not the count has run out. A burst that is in progress when the edge arrives ends once the beat on the port has been accepted. A lost or extra group in one frame therefore cannot shift the placement of any later frame. When the count reaches zero, the block pulses a frame-done output. It then ignores requests until the next frame-sync.

Top module: `fb_burst_writer`

## Requirements
- R1: During and after reset, grp_ack_o, mem_we_o and frame_done_o are low. Until the first frame-sync edge, no request is acknowledged and no write is issued.
- R2: A frame-sync edge is a cycle in which fsync_i is sampled high after having been sampled low in the previous cycle. base_addr_i is sampled in that cycle, and the next burst starts at that address.
- R3: An accepted request produces exactly eight write beats. The address rises by 4 from each beat to the next. Beat k carries bits [32k+31:32k] of the grp_data_i value captured when the request was accepted.
- R4: A beat completes only in a cycle with mem_ready_i high. While mem_we_o is high and mem_ready_i is low, mem_addr_o and mem_wdata_o hold their values.
- R5: When FRAME_BURSTS bursts have completed since the last frame-sync, frame_done_o is high for exactly one cycle, in the cycle after the last beat is accepted. Requests after that are not acknowledged and cause no writes until the next frame-sync edge.
- R6: If a frame-sync edge arrives during a burst, the beat on the port completes when mem_ready_i is high. No further beat of that burst is issued, and the restore of R2 and R7 then applies.
- R7: Every frame-sync edge reloads the burst count to FRAME_BURSTS, even when the count has not reached zero.
- R8: grp_ack_o is a one-cycle pulse in the same cycle as the first beat of the accepted burst. A request held high is not accepted again until the current burst has ended.
- R9: A change of base_addr_i outside a frame-sync edge cycle has no effect on the write addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync level; its rising edge restores address and count |
| base_addr_i | input | ADDR_W | Frame buffer start address, sampled on the frame-sync edge |
| grp_req_i | input | 1 | Capture group ready to be written |
| grp_data_i | input | BEATS*DATA_W | Capture group, word 0 in the low bits |
| grp_ack_o | output | 1 | One-cycle acceptance pulse |
| mem_we_o | output | 1 | Write beat valid |
| mem_addr_o | output | ADDR_W | Byte address of the beat |
| mem_wdata_o | output | DATA_W | Beat data |
| mem_ready_i | input | 1 | Memory accepts the beat on the port |
| frame_done_o | output | 1 | One-cycle pulse when the frame's last burst has been written |

## Verification
The assertions check the local timing on every cycle. They cover: address and data held under memory stall, an address step of one word after each beat, the acknowledge pulse sitting on the first beat, the frame-done pulse lasting one cycle and disarming the writer, the burst stopping after an aborted beat, and the count being reloaded after a restore. Other behaviour needs a full scenario and is shown only by the bench's model. That covers: where each frame's bursts land after a mid-burst frame-sync, the base address being ignored between edges, requests being refused after frame end or before the first frame-sync, and frame-done coming exactly after FRAME_BURSTS bursts.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } fbw_state_e;
endpackage

// File: rtl/fbw_rst_sync.sv
module fbw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/fbw_sync_edge.sv
module fbw_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  output logic edge_o
);
  logic fsync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsync_q <= 1'b0;
    else        fsync_q <= fsync_i;
  end

  assign edge_o = fsync_i & ~fsync_q;
endmodule

// File: rtl/fbw_frame_ctr.sv
module fbw_frame_ctr #(
  parameter int ADDR_W       = 32,
  parameter int FRAME_BURSTS = 4800,
  parameter int STEP         = 4,
  localparam int CNT_W       = $clog2(FRAME_BURSTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_edge_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              restore_i,
  input  logic              beat_done_i,
  input  logic              burst_end_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              armed_o,
  output logic              frame_done_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              done_q, done_d;
  logic              base_en, addr_en, rem_en;
  logic [ADDR_W-1:0] restore_base;

  // next-state logic
  always_comb begin
    restore_base = sync_edge_i ? base_addr_i : base_q;
    base_en      = sync_edge_i;
    base_d       = base_addr_i;
    addr_en      = restore_i | beat_done_i;
    addr_d       = restore_i ? restore_base : (addr_q + ADDR_W'(STEP));
    rem_en       = restore_i | burst_end_i;
    rem_d        = restore_i ? CNT_W'(FRAME_BURSTS) : (rem_q - CNT_W'(1));
    done_d       = burst_end_i & ~restore_i & (rem_q == CNT_W'(1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      if (addr_en) addr_q <= addr_d;
      if (rem_en)  rem_q  <= rem_d;
      done_q <= done_d;
    end
  end

  assign addr_o       = addr_q;
  assign armed_o      = (rem_q != '0);
  assign frame_done_o = done_q;

  // R7
  restore_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> armed_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  // R5
  done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> !armed_o);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done_i && !restore_i) |=> (addr_o == $past(addr_o) + ADDR_W'(STEP)));
endmodule

// File: rtl/fbw_burst_seq.sv
module fbw_burst_seq
  import fbw_pkg::*;
#(
  parameter int BEATS  = 8,
  parameter int DATA_W = 32,
  localparam int GRP_W  = BEATS * DATA_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_edge_i,
  input  logic              armed_i,
  input  logic              grp_req_i,
  input  logic [GRP_W-1:0]  grp_data_i,
  input  logic              mem_ready_i,
  output logic              grp_ack_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              restore_o,
  output logic              beat_done_o,
  output logic              burst_end_o
);
  fbw_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              pend_q, pend_d;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] word_q [BEATS];
  logic              busy, sync_req, last_beat, start, beat_en;

  always_comb begin
    busy        = (state_q == ST_BURST);
    sync_req    = sync_edge_i | pend_q;
    beat_done_o = busy & mem_ready_i;
    last_beat   = (beat_q == BEAT_W'(BEATS - 1));
    restore_o   = sync_req & (~busy | beat_done_o);
    start       = ~busy & ~sync_req & grp_req_i & armed_i;
    burst_end_o = beat_done_o & last_beat & ~sync_req;

    state_d = state_q;
    if (restore_o)        state_d = ST_IDLE;
    else if (start)       state_d = ST_BURST;
    else if (burst_end_o) state_d = ST_IDLE;

    beat_en = start | restore_o | beat_done_o;
    if (start | restore_o)  beat_d = '0;
    else if (last_beat)     beat_d = '0;
    else                    beat_d = beat_q + BEAT_W'(1);

    if (restore_o)                  pend_d = 1'b0;
    else if (sync_edge_i && busy)   pend_d = 1'b1;
    else                            pend_d = pend_q;

    ack_d = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
      pend_q  <= pend_d;
      ack_q   <= ack_d;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q[g] <= '0;
      else if (start) word_q[g] <= grp_data_i[g*DATA_W +: DATA_W];
    end
  end

  assign grp_ack_o   = ack_q;
  assign mem_we_o    = busy;
  assign mem_wdata_o = word_q[beat_q];

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_wdata_o)));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ack_o |=> !grp_ack_o);
  // R6
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_ready_i && sync_req) |=> !mem_we_o);
  // R1
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ack_o |-> $past(armed_i));
endmodule

// File: rtl/fb_burst_writer.sv
module fb_burst_writer #(
  parameter int DATA_W       = 32,
  parameter int BEATS        = 8,
  parameter int ADDR_W       = 32,
  parameter int FRAME_BURSTS = 4800,
  localparam int GRP_W       = BEATS * DATA_W,
  localparam int STEP        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              grp_req_i,
  input  logic [GRP_W-1:0]  grp_data_i,
  output logic              grp_ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  output logic              frame_done_o
);
  logic rst_int_n;
  logic sync_edge;
  logic armed, restore, beat_done, burst_end;

  fbw_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fbw_sync_edge i_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fsync_i (fsync_i),
    .edge_o  (sync_edge)
  );

  fbw_burst_seq #(
    .BEATS  (BEATS),
    .DATA_W (DATA_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sync_edge_i (sync_edge),
    .armed_i     (armed),
    .grp_req_i   (grp_req_i),
    .grp_data_i  (grp_data_i),
    .mem_ready_i (mem_ready_i),
    .grp_ack_o   (grp_ack_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .restore_o   (restore),
    .beat_done_o (beat_done),
    .burst_end_o (burst_end)
  );

  fbw_frame_ctr #(
    .ADDR_W       (ADDR_W),
    .FRAME_BURSTS (FRAME_BURSTS),
    .STEP         (STEP)
  ) i_ctr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sync_edge_i  (sync_edge),
    .base_addr_i  (base_addr_i),
    .restore_i    (restore),
    .beat_done_i  (beat_done),
    .burst_end_i  (burst_end),
    .addr_o       (mem_addr_o),
    .armed_o      (armed),
    .frame_done_o (frame_done_o)
  );

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_we_o && !mem_ready_i) |=> $stable(mem_addr_o));
  // R8
  ack_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    grp_ack_o |-> mem_we_o);
  // R5
  done_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_done_o |-> (!grp_ack_o && !mem_we_o));
endmodule

// File: tb/test_fb_burst_writer.sv
module test_fb_burst_writer;
  localparam int DW = 32;
  localparam int NB = 8;
  localparam int AW = 32;
  localparam int FB = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, fsync, req, ready;
  logic [AW-1:0]  base;
  logic [NB*DW-1:0] data;
  logic           ack, we, done;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata;

  fb_burst_writer #(.DATA_W(DW), .BEATS(NB), .ADDR_W(AW), .FRAME_BURSTS(FB)) i_fb_burst_writer (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .base_addr_i(base),
    .grp_req_i(req), .grp_data_i(data), .grp_ack_o(ack),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ready_i(ready), .frame_done_o(done));

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    stall_en = 0;
  int    done_seen = 0;

  // behavioural reference model
  int            m_cnt = 0;
  bit            m_busy, m_pend, m_prev, e_ack, e_done;
  int            m_beat, m_rem;
  logic [AW-1:0] m_addr, m_base;
  logic [DW-1:0] m_words [$];

  always @(posedge clk) begin
    bit edge_now, sreq;
    if (!rst_n) m_cnt = 0;
    else if (m_cnt < 3) m_cnt++;
    e_ack = 0; e_done = 0;
    if (m_cnt < 3) begin
      m_busy = 0; m_pend = 0; m_prev = 0; m_beat = 0; m_rem = 0;
      m_addr = '0; m_base = '0; m_words = {};
    end else begin
      edge_now = fsync && !m_prev;
      m_prev   = fsync;
      if (edge_now) m_base = base;
      sreq = edge_now || m_pend;
      if (m_busy) begin
        if (sreq && ready) begin
          m_busy = 0; m_pend = 0; m_addr = m_base; m_rem = FB;
        end else begin
          if (edge_now) m_pend = 1;
          if (ready) begin
            m_addr = m_addr + 4;
            m_beat++;
            if (m_beat == NB) begin
              m_busy = 0;
              m_rem--;
              if (m_rem == 0) e_done = 1;
            end
          end
        end
      end else if (sreq) begin
        m_pend = 0; m_addr = m_base; m_rem = FB;
      end else if (req && m_rem != 0) begin
        m_busy = 1; m_beat = 0; e_ack = 1;
        m_words = {};
        for (int k = 0; k < NB; k++) m_words.push_back(data[k*DW +: DW]);
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (done) done_seen++;
    chk("mem_we", {31'b0, we}, {31'b0, m_busy});
    chk("grp_ack", {31'b0, ack}, {31'b0, e_ack});
    chk("frame_done", {31'b0, done}, {31'b0, e_done});
    if (m_busy && we) begin
      chk("mem_addr", addr, m_addr);
      chk("mem_wdata", wdata, m_words[m_beat]);
    end
  end

  always @(negedge clk) ready <= stall_en ? 1'($urandom % 2) : 1'b1;

  function automatic logic [NB*DW-1:0] mk(int seed);
    logic [NB*DW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*DW +: DW] = {16'(seed), 16'(k + 1) * 16'h1111};
    return v;
  endfunction

  task automatic burst(logic [NB*DW-1:0] d);
    @(negedge clk); data = d; req = 1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (ack) break;
    end
    @(negedge clk); req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    for (int i = 0; i < 200 && we; i++) @(negedge clk);
  endtask

  task automatic pulse_sync(logic [AW-1:0] b);
    @(negedge clk); base = b; fsync = 1;
    repeat (3) @(negedge clk);
    fsync = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; fsync = 0; req = 0; base = 32'h0; data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1: request before any frame-sync must be ignored
    cur_req = "R1";
    burst(mk(1));
    // R2: first frame-sync sets base
    cur_req = "R2";
    pulse_sync(32'h1000_0000);
    // R3: plain bursts, memory always ready
    cur_req = "R3";
    burst(mk(2)); wait_idle();
    burst(mk(3)); wait_idle();
    // R4: bursts under memory stalls
    cur_req = "R4";
    stall_en = 1;
    burst(mk(4)); wait_idle();
    stall_en = 0;
    // R6: frame-sync in the middle of a burst
    cur_req = "R6";
    @(negedge clk); data = mk(6); req = 1;
    for (int i = 0; i < 40 && !ack; i++) @(negedge clk);
    req = 0;
    @(negedge clk);
    base = 32'h2000_0000; fsync = 1;
    repeat (3) @(negedge clk);
    fsync = 0;
    wait_idle();
    // R9: base change without edge has no effect
    cur_req = "R9";
    base = 32'h3000_0000;
    burst(mk(7)); wait_idle();
    // R8: request held high across bursts
    cur_req = "R8";
    @(negedge clk); data = mk(8); req = 1;
    repeat (12) @(negedge clk);
    req = 0;
    wait_idle();
    // R7 / R5: count reloaded by mid-frame sync; frame ends after FB bursts
    cur_req = "R7";
    done_seen = 0;
    for (int n = 0; n < 4; n++) begin
      cur_req = (n == 3) ? "R5" : "R7";
      burst(mk(20 + n)); wait_idle();
    end
    cur_req = "R5";
    chk("frame_done count", done_seen, 1);
    burst(mk(30));
    chk("frame_done count after ignored request", done_seen, 1);
    // R7: new frame accepted again after sync
    cur_req = "R7";
    pulse_sync(32'h4000_0000);
    burst(mk(31)); wait_idle();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule